// File: doc/BRIEF.md
# Two-Wire Bus Clock Timer with Post-Stretch Data Setup

This block produces the serial clock of a two-wire bus controller for the standard and fast speed classes. The clock is built from a 16-bit baud count and a 2-bit speed selector. It releases or pulls the clock line, reads the line back to see whether a target is stretching the clock, and gives the byte engine two one-cycle strobes. The first strobe marks where SDA may change, in the middle of the low phase. The second marks where SDA should be sampled, in the middle of the high phase.

The state machine has five states. `ST_IDLE` leaves the line released. `ST_LOW` pulls the clock low. `ST_HIGH` releases the line and counts the high phase. `ST_STRETCH` waits, with the count frozen, while the released line still reads low. `ST_HOLD` keeps the line released after the high phase has ended, until the setup delay has run out.

The transitions are:
- idle-to-low, taken when `run` is seen high.
- low-to-high, taken when the low count ends.
- high-to-stretch, taken when the line reads low while released.
- stretch-to-high, taken when the line reads high again. This transition loads the setup counter.
- high-to-low, taken when the high count ends and the setup counter is zero.
- high-to-hold, taken when the high count ends and the setup counter is not zero.
- hold-to-low, taken when the setup counter reaches zero.
- any-to-idle, taken when `run` is seen low.

Top module: `scl_baud_timer`

## Requirements
- R1: Out of reset the line is released (`scl_pull`=0), both strobes are 0 and `busy` is 0.
- R2: When `speed_sel` is 2'b00 (standard), the low phase and the high phase each last N cycles, where N is `baud_word[15:0]`.
- R3: When `speed_sel` is 2'b01 (fast), the low phase lasts 2N cycles and the high phase lasts N cycles.
- R4: When `speed_sel` is 2'b10 or 2'b11, the block uses the standard timing of R2.
- R5: A baud count of 0 behaves exactly like a count of 1, so the clock never stalls. The clock period is then 2 cycles.
- R6: `baud_word[31:16]` is ignored. Any value there gives the same timing as zero.
- R7: While the line is released but reads low, the high-phase count is frozen, no sample strobe is given and the line is not pulled low.
- R8: When a stretch ends, S = `setup_word[31:16]` is loaded. The cycle in which the line is first seen high again is spent leaving the stretch. The next low phase then begins after max(H, S+1) more cycles, where H is the high-phase length.
- R9: `run` seen high at a clock edge starts a low phase from that edge. `run` seen low returns the block to idle at that edge, with the line released and `busy`=0.
- R10: The SDA-change strobe fires in low-phase cycle floor(L/2), counting from zero, where L is the low-phase length. The sample strobe fires in high-phase cycle floor(H/2), and only while the line reads high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | Generate clocks while high |
| baud_word | input | 32 | Baud register word; bits 15:0 give N, bits 31:16 are ignored |
| speed_sel | input | 2 | Speed selector: 00 standard, 01 fast, others fall back to standard |
| setup_word | input | 32 | Setup register word; bits 31:16 give the post-stretch setup count |
| scl_in | input | 1 | Clock line read back |
| scl_pull | output | 1 | 1 pulls the clock line low, 0 releases it |
| sda_strobe | output | 1 | One-cycle pulse at the SDA change point |
| sample_strobe | output | 1 | One-cycle pulse at the SDA sample point |
| busy | output | 1 | High whenever the block is not idle |

## Verification
Every output comes from the registered state and phase count, and the sample strobe is also gated by the live line. A change of `run` therefore appears one clock edge later. A release of the line by the target shows up one edge after the block sees it. The low phase begins max(H, S+1)+1 cycles after the line is released.

The bench keeps a cycle-level behavioural model that follows the same edge accounting and compares all four outputs on every falling edge. Counting windows start on the falling edge at which `run` is raised, so each window covers whole clock periods. The stretch cases count falling edges from the release of the line to the next pull.

// File: rtl/scl_timer_pkg.sv
package scl_timer_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_LOW     = 3'd1,
        ST_HIGH    = 3'd2,
        ST_STRETCH = 3'd3,
        ST_HOLD    = 3'd4
    } scl_state_t;

    localparam logic [1:0] SPD_STD  = 2'b00;
    localparam logic [1:0] SPD_FAST = 2'b01;
endpackage

// File: rtl/scl_phase_len.sv
module scl_phase_len
    import scl_timer_pkg::*;
#(
    parameter int BAUD_W = 16,
    localparam int LEN_W = BAUD_W + 1
) (
    input  logic [BAUD_W-1:0] baud_cnt,
    input  logic [1:0]        speed_sel,
    output logic [LEN_W-1:0]  low_len,
    output logic [LEN_W-1:0]  high_len
);
    logic [BAUD_W-1:0] eff_cnt;

    always_comb begin
        // zero count is promoted to one
        eff_cnt  = (baud_cnt == '0) ? BAUD_W'(1) : baud_cnt;
        high_len = {1'b0, eff_cnt};
        if (speed_sel == SPD_FAST) begin
            low_len = {eff_cnt, 1'b0};
        end else begin
            low_len = {1'b0, eff_cnt};
        end
        assert_len_nonzero_R5: assert (low_len != '0 && high_len != '0);
    end
endmodule

// File: rtl/scl_setup_cnt.sv
module scl_setup_cnt #(
    parameter int SETUP_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               load,
    input  logic [SETUP_W-1:0] load_val,
    output logic               expired
);
    logic [SETUP_W-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (clear) begin
            left_q <= '0;
        end else if (load) begin
            left_q <= load_val;
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign expired = (left_q == '0);

    assert_setup_countdown_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !load && left_q != '0) |=> left_q == SETUP_W'($past(left_q) - 1'b1));
endmodule

// File: rtl/scl_baud_timer.sv
module scl_baud_timer
    import scl_timer_pkg::*;
#(
    parameter int REG_W     = 32,
    parameter int BAUD_W    = 16,
    parameter int SETUP_LSB = 16,
    parameter int SETUP_W   = 16,
    localparam int CNT_W    = BAUD_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [REG_W-1:0] baud_word,
    input  logic [1:0]       speed_sel,
    input  logic [REG_W-1:0] setup_word,
    input  logic             scl_in,
    output logic             scl_pull,
    output logic             sda_strobe,
    output logic             sample_strobe,
    output logic             busy
);
    scl_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] low_len, high_len;
    logic             load_setup, setup_zero;
    logic             unused_bits;

    assign unused_bits = ^{baud_word[REG_W-1:BAUD_W], setup_word[SETUP_LSB-1:0]};

    scl_phase_len #(.BAUD_W(BAUD_W)) u_len (
        .baud_cnt  (baud_word[BAUD_W-1:0]),
        .speed_sel (speed_sel),
        .low_len   (low_len),
        .high_len  (high_len)
    );

    scl_setup_cnt #(.SETUP_W(SETUP_W)) u_setup (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (!run),
        .load     (load_setup),
        .load_val (setup_word[SETUP_LSB +: SETUP_W]),
        .expired  (setup_zero)
    );

    always_comb begin
        state_d    = state_q;
        cnt_d      = cnt_q;
        load_setup = 1'b0;
        if (!run) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_LOW;
                    cnt_d   = '0;
                end
                ST_LOW: begin
                    if (cnt_q >= low_len - 1'b1) begin
                        state_d = ST_HIGH;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_HIGH: begin
                    if (!scl_in) begin
                        state_d = ST_STRETCH;
                    end else if (cnt_q >= high_len - 1'b1) begin
                        if (setup_zero) begin
                            state_d = ST_LOW;
                            cnt_d   = '0;
                        end else begin
                            state_d = ST_HOLD;
                        end
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_STRETCH: begin
                    if (scl_in) begin
                        state_d    = ST_HIGH;
                        load_setup = 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (setup_zero) begin
                        state_d = ST_LOW;
                        cnt_d   = '0;
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        scl_pull      = (state_q == ST_LOW);
        busy          = (state_q != ST_IDLE);
        sda_strobe    = (state_q == ST_LOW) && (cnt_q == (low_len >> 1));
        sample_strobe = (state_q == ST_HIGH) && scl_in && (cnt_q == (high_len >> 1));
    end

    assert_low_advances_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOW && run && cnt_q < low_len - 1'b1)
        |=> (state_q == ST_LOW && cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

    assert_stretch_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STRETCH && run && !scl_in) |=> ($stable(cnt_q) && !scl_pull));

    assert_setup_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_HIGH || state_q == ST_HOLD) && !setup_zero) |=> !scl_pull);

    assert_run_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!busy && !scl_pull));
endmodule

// File: tb/sim_scl_baud_timer.sv
`timescale 1ns/1ps
module sim_scl_baud_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [31:0] baud_word = 32'd4;
    logic [1:0]  speed_sel = 2'b00;
    logic [31:0] setup_word = 32'd0;
    logic        slave_hold = 1'b0;
    logic        scl_pull, sda_strobe, sample_strobe, busy;
    wire         line = !scl_pull && !slave_hold;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    scl_baud_timer u0 (
        .clk(clk), .rst_n(rst_n), .run(run), .baud_word(baud_word),
        .speed_sel(speed_sel), .setup_word(setup_word), .scl_in(line),
        .scl_pull(scl_pull), .sda_strobe(sda_strobe),
        .sample_strobe(sample_strobe), .busy(busy)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // behavioural reference: phase 0 idle, 1 low, 2 high, 3 stretch, 4 hold
    int ph = 0, pos = 0, stp = 0;
    function automatic int base_n();
        return (baud_word[15:0] == 16'd0) ? 1 : int'(baud_word[15:0]);
    endfunction
    function automatic int lo_len();
        return (speed_sel == 2'b01) ? 2 * base_n() : base_n();
    endfunction

    always @(posedge clk) begin
        int nstp;
        cyc <= cyc + 1;
        if (!rst_n || !run) begin
            ph <= 0; pos <= 0; stp <= 0;
        end else begin
            nstp = (stp > 0) ? stp - 1 : 0;
            case (ph)
                0: begin ph <= 1; pos <= 0; end
                1: if (pos + 1 >= lo_len()) begin ph <= 2; pos <= 0; end else pos <= pos + 1;
                2: if (!line) ph <= 3;
                   else if (pos + 1 >= base_n()) begin
                       if (stp == 0) begin ph <= 1; pos <= 0; end else ph <= 4;
                   end else pos <= pos + 1;
                3: if (line) begin ph <= 2; nstp = int'(setup_word[31:16]); end
                default: if (stp == 0) begin ph <= 1; pos <= 0; end
            endcase
            stp <= nstp;
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            chk("R2 scl_pull vs model", int'(scl_pull), int'(ph == 1));
            chk("R10 sda_strobe vs model", int'(sda_strobe), int'(ph == 1 && pos == lo_len() / 2));
            chk("R10 sample_strobe vs model", int'(sample_strobe),
                int'(ph == 2 && line && pos == base_n() / 2));
            chk("R9 busy vs model", int'(busy), int'(ph != 0));
        end
    end

    task automatic window(input int n, output int pulls, output int sdas, output int smps);
        pulls = 0; sdas = 0; smps = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            pulls += int'(scl_pull); sdas += int'(sda_strobe); smps += int'(sample_strobe);
        end
    endtask

    task automatic start(input logic [31:0] bw, input logic [1:0] sp, input logic [31:0] sw);
        baud_word = bw; speed_sel = sp; setup_word = sw; run = 1'b1;
    endtask

    task automatic stop_run(input string tag);
        run = 1'b0;
        @(negedge clk);
        chk(tag, int'(busy), 0);
        chk(tag, int'(scl_pull), 0);
        repeat (2) @(negedge clk);
    endtask

    task automatic stretch_case(input int s, input int exp_gap);
        int gap;
        start(32'd5, 2'b00, 32'(s) << 16);
        @(negedge clk);
        slave_hold = 1'b1;
        repeat (10) @(negedge clk);
        chk("R7 line held, no pull", int'(scl_pull), 0);
        chk("R7 no sample while held", int'(sample_strobe), 0);
        slave_hold = 1'b0;
        gap = 0;
        do begin
            @(negedge clk);
            gap++;
        end while (!scl_pull && gap < 100);
        chk("R8 release-to-low gap", gap, exp_gap);
        stop_run("R9 idle after stretch run");
    endtask

    initial begin
        int p, d, s;
        repeat (3) @(negedge clk);
        chk("R1 reset pull", int'(scl_pull), 0);
        chk("R1 reset busy", int'(busy), 0);
        chk("R1 reset strobes", int'(sda_strobe | sample_strobe), 0);
        rst_n = 1'b1;
        @(negedge clk);

        start(32'd4, 2'b00, 0);           // standard N=4, period 8
        window(40, p, d, s);
        chk("R2 std low cycles", p, 20); chk("R10 std sda count", d, 5); chk("R10 std sample count", s, 5);
        stop_run("R9 idle after std");

        start(32'd3, 2'b01, 0);           // fast N=3, period 9
        window(36, p, d, s);
        chk("R3 fast low cycles", p, 24); chk("R3 fast sda count", d, 4); chk("R3 fast sample count", s, 4);
        stop_run("R9 idle after fast");

        start(32'd2, 2'b11, 0);           // fallback, period 4
        window(24, p, d, s);
        chk("R4 fallback 11 low cycles", p, 12); chk("R4 fallback 11 sda", d, 6);
        stop_run("R9 idle after fallback 11");

        start(32'd3, 2'b10, 0);           // fallback, period 6
        window(24, p, d, s);
        chk("R4 fallback 10 low cycles", p, 12); chk("R4 fallback 10 sample", s, 4);
        stop_run("R9 idle after fallback 10");

        start(32'd0, 2'b00, 0);           // zero count, period 2
        window(20, p, d, s);
        chk("R5 zero count low cycles", p, 10); chk("R5 zero count sda", d, 10); chk("R5 zero count sample", s, 10);
        stop_run("R9 idle after zero count");

        start(32'hABCD_0004, 2'b00, 0);   // upper half ignored
        window(40, p, d, s);
        chk("R6 upper half low cycles", p, 20); chk("R6 upper half sample", s, 5);
        stop_run("R9 idle after upper half");

        stretch_case(7, 9);               // 1 + max(5, 8)
        stretch_case(1, 6);               // 1 + max(5, 2)

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule